// File: doc/BRIEF.md
# Security-Banked Execution Priority Resolver

The block works out the execution priority a processor core is running at. Two banks of masking state go in, one for the secure world and one for the non-secure world. Each bank has an 8-bit base threshold, an interrupt-disable bit and a fault-mask bit. Two control bits change how the non-secure masks are applied. `prioSecure` keeps non-secure masking at half priority. `faultsToNs` sends faults to the non-secure world. Each bank also has a 3-bit binary point that splits its threshold into group and sub-priority parts.

The masks are applied in a fixed sequence, and each stage may overwrite what the earlier stages produced. The result is then limited by the priority of the active handler. The block registers the result as a 10-bit two's-complement value, so -3, -1 and the idle value 256 can all be expressed. A one-cycle `prioValid` pulse marks each cycle in which a new value appears. Preemption-comparison logic downstream takes the registered value.

Top module: `exec_prio_resolver`

## Requirements
- R1: While reset is held, and in the first cycle after it, `execPrio` is 256 (no exception running) and `prioValid` is 0.
- R2: Base thresholds are applied non-secure first. A nonzero non-secure threshold sets the running value to its group part. A nonzero secure threshold replaces the running value only if its group part is numerically smaller. A threshold of 0 has no effect.
- R3: The group part of a threshold is the threshold with its low n+1 bits cleared, where n is the binary point of the threshold's own bank (`binPtNs` or `binPtS`).
- R4: When `pmNs` is 1 and `prioSecure` is 1, the running value is lowered to 128 if it is above 128 and is otherwise left as it is. When `pmNs` is 1 and `prioSecure` is 0, the running value becomes 0.
- R5: When `pmS` is 1, the running value becomes 0. This step comes after R4.
- R6: When `fmNs` is 1 and `faultsToNs` is 1, the running value becomes -1. When `fmNs` is 1 and `faultsToNs` is 0, the rule of R4 is applied again. This step comes after R5.
- R7: When `fmS` is 1, the running value becomes -3 if `faultsToNs` is 1, or -1 otherwise. This is the last masking step and overrides all earlier ones.
- R8: The output is the smaller, in signed terms, of the masked running value and `activePrio`.
- R9: The output register loads the resolved value on the clock edge after its inputs are presented. `prioValid` is 1 in exactly those cycles where `execPrio` differs from its value in the previous cycle. Otherwise `execPrio` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseNs | input | 8 | Non-secure base threshold |
| baseS | input | 8 | Secure base threshold |
| pmNs | input | 1 | Non-secure interrupt-disable bit |
| pmS | input | 1 | Secure interrupt-disable bit |
| fmNs | input | 1 | Non-secure fault-mask bit |
| fmS | input | 1 | Secure fault-mask bit |
| prioSecure | input | 1 | Caps non-secure masking at 128 instead of 0 |
| faultsToNs | input | 1 | Faults target the non-secure world |
| binPtNs | input | 3 | Non-secure binary point |
| binPtS | input | 3 | Secure binary point |
| activePrio | input | 10 | Signed priority of the active handler |
| execPrio | output | 10 | Signed resolved execution priority |
| prioValid | output | 1 | Pulses when a new value appears on execPrio |

## Verification
The bench places the secure threshold both above and below 128 while the non-secure disable bit and `prioSecure` are set. A design that clamps without comparing would lose a secure threshold below 128. A design that lets the disable bit short-circuit the thresholds would report 128 where the threshold should win. The bench also sets the non-secure fault mask with `faultsToNs` clear, which a design that always returns -1 would get wrong. It sets the secure fault mask with `faultsToNs` set, to catch -3 being confused with -1. It uses binary point 7 and a threshold of 0 to catch a design that tests for a nonzero threshold after masking rather than before, or that applies the wrong bank's grouping. Repeated identical inputs check that `prioValid` stays low when nothing changes.

// File: rtl/prio_pkg.sv
package prio_pkg;
  typedef struct packed {
    logic load;
    logic markValid;
  } ctrlStrobes_t;

  function automatic logic [7:0] groupMask8(input logic [2:0] binPt);
    logic [7:0] m;
    m = 8'hFF << (32'(binPt) + 32'd1);
    return m;
  endfunction
endpackage

// File: rtl/prio_ctrl.sv
module prio_ctrl
  import prio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         changed,
  output ctrlStrobes_t strobes,
  output logic         validQ
);
  always_comb begin
    strobes.load      = changed;
    strobes.markValid = changed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobes.markValid;
  end
endmodule

// File: rtl/prio_datapath.sv
module prio_datapath
  import prio_pkg::*;
#(
  parameter int PRIO_W = 10,
  parameter int LVL_W  = 8,
  parameter int BP_W   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LVL_W-1:0]         baseNs,
  input  logic [LVL_W-1:0]         baseS,
  input  logic                     pmNs,
  input  logic                     pmS,
  input  logic                     fmNs,
  input  logic                     fmS,
  input  logic                     prioSecure,
  input  logic                     faultsToNs,
  input  logic [BP_W-1:0]          binPtNs,
  input  logic [BP_W-1:0]          binPtS,
  input  logic signed [PRIO_W-1:0] activePrio,
  input  ctrlStrobes_t             strobes,
  output logic                     changed,
  output logic signed [PRIO_W-1:0] heldQ
);
  localparam int NBANK = 2;
  localparam int EXT_W = PRIO_W - LVL_W;
  localparam logic signed [PRIO_W-1:0] NOEXC  = PRIO_W'(1 << LVL_W);
  localparam logic signed [PRIO_W-1:0] NS_CAP = PRIO_W'(1 << (LVL_W - 1));
  localparam logic signed [PRIO_W-1:0] NEG1   = -PRIO_W'(1);
  localparam logic signed [PRIO_W-1:0] NEG3   = -PRIO_W'(3);

  // bank 0 = non-secure, bank 1 = secure
  logic [LVL_W-1:0]         bankBase [NBANK];
  logic [BP_W-1:0]          bankBp   [NBANK];
  logic signed [PRIO_W-1:0] bankGrp  [NBANK];
  logic                     bankOn   [NBANK];

  assign bankBase[0] = baseNs;
  assign bankBase[1] = baseS;
  assign bankBp[0]   = binPtNs;
  assign bankBp[1]   = binPtS;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [LVL_W-1:0] grpMask;
    always_comb begin
      grpMask = {LVL_W{1'b1}} << (32'(bankBp[b]) + 32'd1);
      bankGrp[b] = $signed({{EXT_W{1'b0}}, bankBase[b] & grpMask});
      bankOn[b]  = (bankBase[b] != '0);
    end
  end

  logic signed [PRIO_W-1:0] running;
  logic signed [PRIO_W-1:0] resolved;

  always_comb begin
    running = NOEXC;
    if (bankOn[0]) running = bankGrp[0];
    if (bankOn[1] && (running > bankGrp[1])) running = bankGrp[1];
    if (pmNs) begin
      if (prioSecure) begin
        if (running > NS_CAP) running = NS_CAP;
      end else begin
        running = '0;
      end
    end
    if (pmS) running = '0;
    if (fmNs) begin
      if (faultsToNs) running = NEG1;
      else if (prioSecure) begin
        if (running > NS_CAP) running = NS_CAP;
      end else begin
        running = '0;
      end
    end
    if (fmS) running = faultsToNs ? NEG3 : NEG1;
    resolved = (running < activePrio) ? running : activePrio;
  end

  assign changed = (resolved != heldQ);

  always_ff @(posedge clk) begin
    if (!rstN)             heldQ <= NOEXC;
    else if (strobes.load) heldQ <= resolved;
  end
endmodule

// File: rtl/exec_prio_resolver.sv
module exec_prio_resolver
  import prio_pkg::*;
#(
  parameter int PRIO_W = 10,
  parameter int LVL_W  = 8,
  parameter int BP_W   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LVL_W-1:0]         baseNs,
  input  logic [LVL_W-1:0]         baseS,
  input  logic                     pmNs,
  input  logic                     pmS,
  input  logic                     fmNs,
  input  logic                     fmS,
  input  logic                     prioSecure,
  input  logic                     faultsToNs,
  input  logic [BP_W-1:0]          binPtNs,
  input  logic [BP_W-1:0]          binPtS,
  input  logic signed [PRIO_W-1:0] activePrio,
  output logic signed [PRIO_W-1:0] execPrio,
  output logic                     prioValid
);
  ctrlStrobes_t strobes;
  logic         changed;

  prio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .changed(changed),
    .strobes(strobes), .validQ(prioValid)
  );

  prio_datapath #(.PRIO_W(PRIO_W), .LVL_W(LVL_W), .BP_W(BP_W)) u_dp (
    .clk(clk), .rstN(rstN), .baseNs(baseNs), .baseS(baseS),
    .pmNs(pmNs), .pmS(pmS), .fmNs(fmNs), .fmS(fmS),
    .prioSecure(prioSecure), .faultsToNs(faultsToNs),
    .binPtNs(binPtNs), .binPtS(binPtS), .activePrio(activePrio),
    .strobes(strobes), .changed(changed), .heldQ(execPrio)
  );
endmodule

// File: rtl/exec_prio_resolver_chk.sv
module exec_prio_resolver_chk #(
  parameter int PRIO_W = 10
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     pmS,
  input logic                     fmS,
  input logic                     faultsToNs,
  input logic signed [PRIO_W-1:0] activePrio,
  input logic signed [PRIO_W-1:0] execPrio,
  input logic                     prioValid
);
  localparam logic signed [PRIO_W-1:0] NOEXC = PRIO_W'(256);

  a_r1_reset_idle: assert property (@(posedge clk) !rstN |=> (execPrio == NOEXC && !prioValid));

  a_r9_hold_without_valid: assert property (@(posedge clk) disable iff (!rstN)
    !prioValid |-> $stable(execPrio));

  a_r9_valid_means_change: assert property (@(posedge clk) disable iff (!rstN)
    prioValid |-> execPrio != $past(execPrio));

  a_r8_not_above_active: assert property (@(posedge clk) disable iff (!rstN)
    prioValid |-> execPrio <= $past(activePrio));

  a_r5_secure_disable: assert property (@(posedge clk) disable iff (!rstN)
    (prioValid && $past(pmS)) |-> execPrio <= 0);

  a_r7_secure_fault: assert property (@(posedge clk) disable iff (!rstN)
    (prioValid && $past(fmS) && $past(faultsToNs)) |-> execPrio <= -PRIO_W'(3));

  a_r2_upper_bound: assert property (@(posedge clk) disable iff (!rstN)
    execPrio <= NOEXC);
endmodule

bind exec_prio_resolver exec_prio_resolver_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rstN(rstN), .pmS(pmS), .fmS(fmS), .faultsToNs(faultsToNs),
  .activePrio(activePrio), .execPrio(execPrio), .prioValid(prioValid)
);

// File: tb/sim_exec_prio_resolver.sv
module sim_exec_prio_resolver;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] baseNs = '0, baseS = '0;
  logic pmNs = 0, pmS = 0, fmNs = 0, fmS = 0, prioSecure = 0, faultsToNs = 0;
  logic [2:0] binPtNs = '0, binPtS = '0;
  logic signed [9:0] activePrio = 10'sd256;
  logic signed [9:0] execPrio;
  logic prioValid;

  int errors = 0;
  int checks = 0;
  int prevOut = 256;
  bit done = 0;

  always #4 clk = ~clk;

  exec_prio_resolver u0 (
    .clk(clk), .rstN(rstN), .baseNs(baseNs), .baseS(baseS),
    .pmNs(pmNs), .pmS(pmS), .fmNs(fmNs), .fmS(fmS),
    .prioSecure(prioSecure), .faultsToNs(faultsToNs),
    .binPtNs(binPtNs), .binPtS(binPtS), .activePrio(activePrio),
    .execPrio(execPrio), .prioValid(prioValid)
  );

  function automatic int grp(input int v, input int bp);
    int step = 1 << (bp + 1);
    return (v / step) * step;
  endfunction

  function automatic int capNs(input int r);
    if (prioSecure) return (r > 128) ? 128 : r;
    return 0;
  endfunction

  function automatic int refModel();
    int r = 256;
    if (baseNs != 0) r = grp(int'(baseNs), int'(binPtNs));
    if (baseS != 0 && grp(int'(baseS), int'(binPtS)) < r) r = grp(int'(baseS), int'(binPtS));
    if (pmNs) r = capNs(r);
    if (pmS) r = 0;
    if (fmNs) r = faultsToNs ? -1 : capNs(r);
    if (fmS) r = faultsToNs ? -3 : -1;
    if (int'(activePrio) < r) r = int'(activePrio);
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearAll();
    baseNs = 0; baseS = 0; pmNs = 0; pmS = 0; fmNs = 0; fmS = 0;
    prioSecure = 0; faultsToNs = 0; binPtNs = 0; binPtS = 0; activePrio = 10'sd256;
  endtask

  // inputs were changed at a negedge; result is registered at the next posedge
  task automatic step(input string req);
    int exp;
    exp = refModel();
    @(negedge clk);
    check(req, int'(execPrio), exp);
    check({req, " valid"}, int'(prioValid), (exp != prevOut) ? 1 : 0);
    prevOut = exp;
  endtask

  task automatic t_reset();
    check("R1 value", int'(execPrio), 256);
    check("R1 valid", int'(prioValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(execPrio), 256);
    check("R1 valid after release", int'(prioValid), 0);
  endtask

  task automatic t_base();
    clearAll(); baseNs = 8'h60; step("R2 ns base");
    baseS = 8'h80; step("R2 secure larger ignored");
    baseS = 8'h20; step("R2 secure smaller wins");
    baseNs = 0; baseS = 0; step("R2 zero thresholds idle");
  endtask

  task automatic t_grouping();
    clearAll(); baseNs = 8'h57; binPtNs = 3'd3; step("R3 ns bp3");
    baseNs = 0; baseS = 8'h57; binPtS = 3'd1; binPtNs = 3'd6; step("R3 secure own bank bp");
    baseS = 8'h40; binPtS = 3'd7; step("R3 bp7 clears all -> 0");
  endtask

  task automatic t_nsDisable();
    clearAll(); pmNs = 1; step("R4 pmNs no prioSecure -> 0");
    prioSecure = 1; step("R4 cap at 128");
    baseNs = 8'hC0; step("R4 cap above");
    baseNs = 8'h40; step("R4 below cap kept");
  endtask

  task automatic t_corner();
    clearAll(); pmNs = 1; prioSecure = 1;
    baseS = 8'hE0; step("R4 secure above cap");
    baseS = 8'h30; step("R4 secure below cap");
    fmNs = 1; baseS = 8'hF0; step("R6 fmNs cap path");
  endtask

  task automatic t_secDisable();
    clearAll(); baseS = 8'h20; pmNs = 1; prioSecure = 1; pmS = 1; step("R5 secure disable -> 0");
  endtask

  task automatic t_nsFault();
    clearAll(); fmNs = 1; faultsToNs = 1; step("R6 fmNs -> -1");
    faultsToNs = 0; step("R6 fmNs -> 0");
    pmS = 1; prioSecure = 1; step("R6 after pmS stays 0");
  endtask

  task automatic t_secFault();
    clearAll(); fmS = 1; step("R7 fmS -> -1");
    faultsToNs = 1; fmNs = 1; pmS = 1; step("R7 fmS -> -3");
  endtask

  task automatic t_active();
    clearAll(); baseNs = 8'h80; activePrio = 10'sd32; step("R8 active lower");
    activePrio = -10'sd2; step("R8 active negative");
    fmS = 1; faultsToNs = 1; step("R8 mask below active");
  endtask

  task automatic t_hold();
    clearAll(); baseNs = 8'h44; step("R9 change");
    step("R9 no change holds");
    binPtNs = 3'd0; step("R9 same result no pulse");
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      baseNs = 8'($urandom); baseS = 8'($urandom);
      if ($urandom_range(0, 3) == 0) baseNs = 0;
      if ($urandom_range(0, 3) == 0) baseS = 0;
      pmNs = 1'($urandom); pmS = ($urandom_range(0, 5) == 0);
      fmNs = ($urandom_range(0, 3) == 0); fmS = ($urandom_range(0, 7) == 0);
      prioSecure = 1'($urandom); faultsToNs = 1'($urandom);
      binPtNs = 3'($urandom); binPtS = 3'($urandom);
      activePrio = ($urandom_range(0, 1) == 0) ? 10'sd256 : 10'($urandom_range(0, 256));
      step("R2 R4 R6 R7 R8 random");
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    t_base();
    t_grouping();
    t_nsDisable();
    t_corner();
    t_secDisable();
    t_nsFault();
    t_secFault();
    t_active();
    t_hold();
    t_random();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule